// File: doc/BRIEF.md
# Three-Counter Event Monitor

This block counts activity inside a processor core for profiling software. It holds one counter that tracks clock cycles and two counters that each watch one line of an event input vector. The watched line is picked by an 8-bit code in a shared control word. Software uses a four-address register port. Address 0 is the control word. Addresses 1, 2 and 3 are the cycle counter, event counter 0 and event counter 1. All counters are 32 bits wide and can be read or loaded at any time.

The two event counters cannot be switched on or off one at a time. A single global enable starts and stops all three counters. To stop one event counter on its own, software points it at code 0x20. That code watches a spare line which is held low while the counter is parked. Each counter has a sticky wrap flag and a matching interrupt enable. One interrupt line is high while any enabled flag is set. Software can read the control word and write the same value back. The only effect of that write-back is to clear the flags that were set.

Top module: `perf_monitor`

## Requirements
- R1: After reset, all three counters read 0, the control word reads 0 and `irq` is low.
- R2: The control word reads back with these fields:
  - bit 0 is the global enable;
  - bit 3 is the cycle divider;
  - bits 6:4 are the interrupt enables for event counter 0, event counter 1 and the cycle counter, in that order;
  - bits 10:8 are the wrap flags, in the same order;
  - bits 27:20 are the event code for counter 0;
  - bits 19:12 are the event code for counter 1;
  - all other bits read 0.
- R3: A write to address 1, 2 or 3 loads that counter. The new value is readable from the next cycle. A load takes priority over counting in the same cycle.
- R4: With the enable set, the cycle counter advances by 1 every clock. With the enable clear, no counter changes.
- R5: With the divider bit set, the cycle counter advances once every 64 enabled clocks, counted from its last reset.
- R6: An event code c below 33 counts each enabled clock on which `evt_in[c]` is high. Code 0xFF counts every enabled clock. Any other code counts nothing.
- R7: Code 0x20 watches `evt_in[32]`. While that line is low, a counter set to code 0x20 keeps its value.
- R8: Writing 1 to control bit 1 zeroes both event counters. Writing 1 to control bit 2 zeroes the cycle counter and its divider phase. Each reset acts only on the cycle of the write, and both bits always read 0.
- R9: A counter that steps from 0xFFFFFFFF to 0 sets its wrap flag at the same clock edge. The flag then stays set.
- R10: Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. Writing back a value read from the control word changes nothing except clearing the flags that were set.
- R11: `irq` is high exactly while some wrap flag and its matching interrupt enable are both set. It is visible right after the edge that sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address: 0 control, 1 cycle, 2 event 0, 3 event 1 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| evt_in | input | 33 | Event lines; bit 32 is the parking line |
| irq | output | 1 | Shared interrupt request |

## Verification
Reads are combinational, so the bench samples `reg_rdata` within the same cycle it sets the address, well away from any edge. Each write or count takes effect at the next rising edge.

The write that turns the enable off still counts on its own edge, because the enable register only drops at that edge. Every expected count therefore includes that final edge. The same holds for the divider: a divided run of 200 cycles plus the disabling edge must give 3.

A flag and `irq` are sampled one time unit after the edge on which the counter wraps, never earlier. The random rounds build up their expected counts cycle by cycle, using the same input vector the design sees at each edge.

// File: rtl/perf_monitor.sv
module perf_monitor #(
  parameter int CNT_W    = 32,
  parameter int EVT_W    = 33,
  parameter int DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0] evt_in,
  output logic             irq
);
  localparam int SW = $clog2(EVT_W);

  logic                en, dv;
  logic [2:0]          ien, ovf;
  logic [7:0]          sel0, sel1;
  logic [DIV_LOG2-1:0] pre;
  logic [CNT_W-1:0]    cnt [3];
  logic [2:0]          inc, load, clr, wrap;
  logic                ctrl_wr;

  function automatic logic hit(input logic [7:0] s, input logic [EVT_W-1:0] e);
    if (s == 8'hFF) return 1'b1;
    if (int'(s) < EVT_W) return e[s[SW-1:0]];
    return 1'b0;
  endfunction

  assign ctrl_wr = reg_wr && reg_addr == 2'd0;
  assign inc[0]  = en && (!dv || &pre);
  assign inc[1]  = en && hit(sel0, evt_in);
  assign inc[2]  = en && hit(sel1, evt_in);
  assign clr[0]  = ctrl_wr && reg_wdata[2];
  assign clr[1]  = ctrl_wr && reg_wdata[1];
  assign clr[2]  = clr[1];

  always_comb
    for (int i = 0; i < 3; i++) begin
      load[i] = reg_wr && reg_addr == 2'(i + 1);
      wrap[i] = inc[i] && &cnt[i] && !load[i] && !clr[i];
    end

  always_ff @(posedge clk)
    for (int i = 0; i < 3; i++)
      if (!rst_n)       cnt[i] <= '0;
      else if (load[i]) cnt[i] <= reg_wdata;
      else if (clr[i])  cnt[i] <= '0;
      else if (inc[i])  cnt[i] <= cnt[i] + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n)          pre <= '0;
    else if (clr[0])     pre <= '0;
    else if (en && dv)   pre <= pre + 1'b1;

  always_ff @(posedge clk)
    if (!rst_n) begin
      en <= 1'b0; dv <= 1'b0; ien <= '0; sel0 <= '0; sel1 <= '0; ovf <= '0;
    end else begin
      if (ctrl_wr) begin
        en   <= reg_wdata[0];
        dv   <= reg_wdata[3];
        ien  <= reg_wdata[6:4];
        sel0 <= reg_wdata[27:20];
        sel1 <= reg_wdata[19:12];
      end
      ovf <= (ovf & ~(ctrl_wr ? reg_wdata[10:8] : 3'b000)) | {wrap[0], wrap[2], wrap[1]};
    end

  assign irq = |(ovf & ien);

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = CNT_W'({4'b0, sel0, sel1, 1'b0, ovf, 1'b0, ien, dv, 2'b0, en});
      2'd1:    reg_rdata = cnt[0];
      2'd2:    reg_rdata = cnt[1];
      default: reg_rdata = cnt[2];
    endcase

  // R3
  wr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd2 |=> cnt[1] == $past(reg_wdata));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !reg_wr |=> $stable(cnt[0]) && $stable(cnt[1]) && $stable(cnt[2]));
  // R6
  no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit(sel0, evt_in) && !reg_wr |=> $stable(cnt[1]));
  // R9
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && sel0 == 8'hFF && &cnt[1] && !reg_wr |=> ovf[0] && cnt[1] == '0);
  // R10
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && reg_wdata[8] && !(&cnt[1]) |=> !ovf[0]);
endmodule

// File: tb/test_perf_monitor.sv
`timescale 1ns/1ps
module test_perf_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [32:0] evt_in = '0;
  logic        irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  perf_monitor i_perf_monitor (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq)
  );

  localparam logic [31:0] SNONE = (32'h40 << 20) | (32'h40 << 12);

  function automatic int ref_hit(input logic [7:0] s, input logic [32:0] e);
    if (s == 8'hFF) return 1;
    if (s < 8'd33) return int'(e[s[5:0]]);
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_wr = 1'b0; reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic fin();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    fin();
  end

  initial begin
    logic [31:0] v, v2;
    logic [7:0]  s0, s1;
    int e0, e1;
    void'($urandom(32'h5EED));
    step(3);
    rst_n = 1'b1;
    step(1);

    for (int a = 0; a < 4; a++) begin rd(2'(a), v); chk("R1 reg after reset", v, 0); end
    chk("R1 irq after reset", {31'b0, irq}, 0);

    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R2/R8 control layout", v, 32'h0FFF_F079);
    wr(0, 32'h0);

    wr(1, 32'hA5A5_0001); wr(2, 32'h1234_5678); wr(3, 32'hCAFE_0000);
    rd(1, v); chk("R3 load cycle", v, 32'hA5A5_0001);
    rd(2, v); chk("R3 load ev0", v, 32'h1234_5678);
    evt_in = '1; step(10); evt_in = '0;
    rd(3, v); chk("R4 disabled hold", v, 32'hCAFE_0000);
    rd(1, v); chk("R4 disabled hold cycle", v, 32'hA5A5_0001);

    wr(0, 32'h2);
    rd(2, v); chk("R8 ev reset 0", v, 0);
    rd(3, v); chk("R8 ev reset 1", v, 0);
    rd(1, v); chk("R8 cycle untouched", v, 32'hA5A5_0001);
    rd(0, v); chk("R8 reset bits read zero", v & 32'h6, 0);
    wr(0, 32'h4);
    rd(1, v); chk("R8 cycle reset", v, 0);

    wr(0, SNONE | 32'h5); step(49); wr(0, SNONE);
    rd(1, v); chk("R4 cycle count", v, 50);
    rd(2, v); chk("R6 unimplemented code", v, 0);

    wr(0, SNONE | 32'hD); step(200); wr(0, SNONE | 32'h8);
    rd(1, v); chk("R5 divider", v, 3);

    wr(0, (32'hFF << 20) | 32'h1); wr(2, 100); wr(0, 32'hFF << 20);
    rd(2, v); chk("R3 load beats count", v, 101);

    evt_in = {1'b0, 32'hFFFF_FFFF};
    wr(0, (32'h20 << 20) | (32'h07 << 12) | 32'h3); step(49); wr(0, (32'h20 << 20) | (32'h07 << 12));
    rd(2, v); chk("R7 parked", v, 0);
    rd(3, v); chk("R6 code 7", v, 50);
    evt_in = {1'b1, 32'h0};
    wr(0, (32'h20 << 20) | (32'h07 << 12) | 32'h3); step(9); wr(0, 32'h0);
    rd(2, v); chk("R7 line high counts", v, 10);
    rd(3, v); chk("R6 line low", v, 0);

    for (int r = 0; r < 8; r++) begin
      case ($urandom % 4)
        0: s0 = 8'hFF; 1: s0 = 8'h40 + 8'($urandom % 64); default: s0 = 8'($urandom % 33);
      endcase
      s1 = 8'($urandom % 33);
      e0 = 0; e1 = 0;
      wr(0, (32'(s0) << 20) | (32'(s1) << 12) | 32'h3);
      for (int i = 0; i < 100; i++) begin
        evt_in = {1'($urandom), $urandom};
        e0 += ref_hit(s0, evt_in); e1 += ref_hit(s1, evt_in);
        step(1);
      end
      evt_in = '0;
      e0 += ref_hit(s0, evt_in); e1 += ref_hit(s1, evt_in);
      wr(0, 32'h0);
      rd(2, v); chk("R6 random ev0", v, 32'(e0));
      rd(3, v); chk("R6 random ev1", v, 32'(e1));
    end

    wr(0, SNONE); wr(2, 32'hFFFF_FFFE);
    wr(0, (32'hFF << 20) | (32'h40 << 12) | 32'h11);
    step(1); chk("R11 irq before wrap", {31'b0, irq}, 0);
    step(1); chk("R11 irq at wrap", {31'b0, irq}, 1);
    rd(2, v); chk("R9 wrapped to zero", v, 0);
    wr(0, (32'hFF << 20) | (32'h40 << 12) | 32'h10);
    rd(0, v); chk("R9 flag sticky", v, 32'h0FF4_0110);
    chk("R11 irq held", {31'b0, irq}, 1);
    wr(0, v & ~32'h100);
    rd(0, v2); chk("R10 write zero keeps flag", v2, v);
    wr(0, v);
    rd(0, v2); chk("R10 writeback clears", v2, 32'h0FF4_0010);
    chk("R10 irq clear", {31'b0, irq}, 0);

    wr(1, 32'hFFFF_FFFF); wr(0, SNONE | 32'h1);
    step(1); chk("R11 gated by enable", {31'b0, irq}, 0);
    wr(0, SNONE | 32'h40);
    chk("R11 enable exposes flag", {31'b0, irq}, 1);
    rd(0, v); chk("R9 cycle flag", v, 32'h0404_0440);
    rd(1, v); chk("R9 cycle after wrap", v, 1);

    fin();
  end
endmodule